// File: doc/BRIEF.md
# Presence-Vector Home Directory Controller

This block is the home node for a small set of memory blocks that several processors cache. Each block has a full presence vector with one bit per processor and a single dirty flag. Requests arrive one at a time, tagged with the requesting processor and a block address. A request is either a read or a write. A write asks for ownership, the same as a read-for-ownership. The controller works out which caches must be contacted and sends them one message. It then waits until every contacted cache has acknowledged. It updates the directory and the backing memory, and only after that does it reply to the requester.

Backing memory is a register array with a fixed read latency. A dirty owner's acknowledgement carries the line's current data. That data is written into memory and forwarded to the requester. A clean sharer's acknowledgement carries no useful data. While a transaction is in flight the block holds its request input not ready. This serializes every access, and so every access to each address.

Top module: `dircoh_home`

## Requirements
- R1: After reset the block is ready for a request, sends no message and gives no reply. Every block is clean with an empty presence vector, and memory block b holds MEM_BASE + b (0x1000 + b by default).
- R2: A read of a clean block sends no message. It replies to the requester with the memory data and rsp_excl = 0. The requester is then added to the presence vector.
- R3: A read of a block that is dirty in another cache sends a recall (msg_kind = 0) to that owner only. The owner's acknowledgement data is written to memory and returned in the reply. Afterwards the block is clean, and both the owner and the requester are present.
- R4: A write to a clean block sends an invalidation (msg_kind = 1) to every present cache except the requester. If that set is empty, no message is sent. The reply has rsp_excl = 1 and carries the memory data.
- R5: A write to a block that is dirty in another cache sends an invalidation to the owner only. The owner's acknowledgement data becomes the new memory contents and the reply data.
- R6: After any write reply, the presence vector holds only the requester and the block is dirty. A later request sees exactly that owner.
- R7: A read or a write from the processor that already owns a dirty block sends no message and is answered from memory. The block stays dirty with the same owner.
- R8: No reply is given until every targeted cache has acknowledged. An acknowledgement from a processor that was not targeted, or one that was already counted, has no effect.
- R9: req_ready is low from the cycle after a request is accepted until the cycle after its reply. Only one transaction is in flight at a time.
- R10: msg_valid is a one-cycle pulse, at most one per transaction, and its target vector is never empty. rsp_valid is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write (ownership request), 0 = read |
| req_pid | input | PIDW | Requesting processor |
| req_addr | input | AW | Block address |
| msg_valid | output | 1 | Coherence message pulse |
| msg_kind | output | 1 | 0 = recall to shared, 1 = invalidate |
| msg_addr | output | AW | Block the message concerns |
| msg_targets | output | NPROC | One bit per destination cache |
| ack_valid | input | 1 | Acknowledgement from a cache |
| ack_pid | input | PIDW | Processor sending the acknowledgement |
| ack_data | input | DW | Line data returned by a dirty owner |
| rsp_valid | output | 1 | Reply pulse to the requester |
| rsp_pid | output | PIDW | Processor the reply is for |
| rsp_addr | output | AW | Block address of the reply |
| rsp_excl | output | 1 | 1 = ownership granted (write reply) |
| rsp_data | output | DW | Line data |

## Verification
The main sequence runs one block through several directory states: first reads from separate processors that build up a sharer set, then a write from one sharer. After that it covers a write and a read repeated by the owner, a read that forces a recall, a write that invalidates two sharers, and a write that takes the line from a dirty owner. Comparing the target vectors across these steps shows whether the requester is left out of the invalidation set, whether a write leaves only one present bit, and whether an owner hit skips messaging. Every transaction with targets also gets an acknowledgement from a processor that was not targeted. The bench checks that the reply waits for all real acknowledgements. Reply data is compared against a model memory, which shows whether dirty data was written back or a stale copy was returned.

// File: rtl/dircoh_pkg.sv
package dircoh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SEND  = 3'd1,
        ST_WAIT  = 3'd2,
        ST_MEMRD = 3'd3,
        ST_REPLY = 3'd4
    } home_st_e;

    typedef enum logic {
        MSG_RECALL = 1'b0,
        MSG_INVAL  = 1'b1
    } msg_kind_e;

endpackage

// File: rtl/dircoh_dir_store.sv
module dircoh_dir_store #(
    parameter int NPROC    = 4,
    parameter int NBLK     = 8,
    parameter int DW       = 16,
    parameter int AW       = 3,
    parameter int MEM_BASE = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    rd_addr,
    output logic [NPROC-1:0] rd_pres,
    output logic             rd_dirty,
    output logic [DW-1:0]    rd_data,
    input  logic [AW-1:0]    wr_addr,
    input  logic             dir_we,
    input  logic [NPROC-1:0] dir_pres,
    input  logic             dir_dirty,
    input  logic             mem_we,
    input  logic [DW-1:0]    mem_wdata
);

    logic [NPROC-1:0] pres_q  [NBLK];
    logic [NPROC-1:0] pres_d  [NBLK];
    logic             dirty_q [NBLK];
    logic             dirty_d [NBLK];
    logic [DW-1:0]    mem_q   [NBLK];
    logic [DW-1:0]    mem_d   [NBLK];

    assign rd_pres  = pres_q[rd_addr];
    assign rd_dirty = dirty_q[rd_addr];
    assign rd_data  = mem_q[rd_addr];

    always_comb begin
        pres_d  = pres_q;
        dirty_d = dirty_q;
        mem_d   = mem_q;
        if (dir_we) begin
            pres_d[wr_addr]  = dir_pres;
            dirty_d[wr_addr] = dir_dirty;
        end
        if (mem_we) begin
            mem_d[wr_addr] = mem_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NBLK; b++) begin
                pres_q[b]  <= '0;
                dirty_q[b] <= 1'b0;
                mem_q[b]   <= DW'(MEM_BASE + b);
            end
        end else begin
            pres_q  <= pres_d;
            dirty_q <= dirty_d;
            mem_q   <= mem_d;
        end
    end

endmodule

// File: rtl/dircoh_target_sel.sv
module dircoh_target_sel #(
    parameter int NPROC = 4,
    parameter int PIDW  = 2
) (
    input  logic [NPROC-1:0] pres,
    input  logic             dirty,
    input  logic             write,
    input  logic [PIDW-1:0]  pid,
    output logic [NPROC-1:0] targets,
    output logic             owner_hit
);

    logic [NPROC-1:0] self_oh;

    for (genvar g = 0; g < NPROC; g++) begin : g_self
        assign self_oh[g] = (pid == PIDW'(g));
    end

    assign owner_hit = dirty && ((pres & self_oh) != '0);

    always_comb begin
        if (dirty && !owner_hit) begin
            targets = pres;
        end else if (!dirty && write) begin
            targets = pres & ~self_oh;
        end else begin
            targets = '0;
        end
    end

endmodule

// File: rtl/dircoh_home.sv
module dircoh_home #(
    parameter int NPROC    = 4,
    parameter int NBLK     = 8,
    parameter int DW       = 16,
    parameter int MEM_LAT  = 2,
    parameter int MEM_BASE = 4096,
    localparam int PIDW    = (NPROC > 1) ? $clog2(NPROC) : 1,
    localparam int AW      = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [PIDW-1:0]  req_pid,
    input  logic [AW-1:0]    req_addr,
    output logic             msg_valid,
    output logic             msg_kind,
    output logic [AW-1:0]    msg_addr,
    output logic [NPROC-1:0] msg_targets,
    input  logic             ack_valid,
    input  logic [PIDW-1:0]  ack_pid,
    input  logic [DW-1:0]    ack_data,
    output logic             rsp_valid,
    output logic [PIDW-1:0]  rsp_pid,
    output logic [AW-1:0]    rsp_addr,
    output logic             rsp_excl,
    output logic [DW-1:0]    rsp_data
);
    import dircoh_pkg::*;

    localparam int LW = (MEM_LAT > 1) ? $clog2(MEM_LAT + 1) : 1;

    typedef struct packed {
        home_st_e         st;
        logic [PIDW-1:0]  pid;
        logic [AW-1:0]    addr;
        logic             write;
        logic             owner;
        logic             was_dirty;
        logic [NPROC-1:0] pend;
        logic [LW-1:0]    lat;
        logic [DW-1:0]    data;
    } regs_t;

    regs_t r_q, r_d;

    logic [AW-1:0]    rd_addr;
    logic [NPROC-1:0] rd_pres;
    logic             rd_dirty;
    logic [DW-1:0]    rd_data;
    logic             dir_we, dir_dirty, mem_we;
    logic [NPROC-1:0] dir_pres;
    logic [DW-1:0]    mem_wdata;
    logic [NPROC-1:0] sel_targets;
    logic             sel_owner;
    logic [NPROC-1:0] ack_oh, pid_oh, pend_left;

    for (genvar g = 0; g < NPROC; g++) begin : g_oh
        assign ack_oh[g] = (ack_pid == PIDW'(g));
        assign pid_oh[g] = (r_q.pid == PIDW'(g));
    end

    assign rd_addr = (r_q.st == ST_IDLE) ? req_addr : r_q.addr;

    dircoh_dir_store #(
        .NPROC(NPROC), .NBLK(NBLK), .DW(DW), .AW(AW), .MEM_BASE(MEM_BASE)
    ) store_i (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(rd_addr), .rd_pres(rd_pres), .rd_dirty(rd_dirty), .rd_data(rd_data),
        .wr_addr(r_q.addr), .dir_we(dir_we), .dir_pres(dir_pres), .dir_dirty(dir_dirty),
        .mem_we(mem_we), .mem_wdata(mem_wdata)
    );

    dircoh_target_sel #(.NPROC(NPROC), .PIDW(PIDW)) sel_i (
        .pres(rd_pres), .dirty(rd_dirty), .write(req_write), .pid(req_pid),
        .targets(sel_targets), .owner_hit(sel_owner)
    );

    assign pend_left = r_q.pend & ~ack_oh;

    always_comb begin
        r_d       = r_q;
        dir_we    = 1'b0;
        dir_pres  = '0;
        dir_dirty = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = ack_data;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.pid       = req_pid;
                    r_d.addr      = req_addr;
                    r_d.write     = req_write;
                    r_d.owner     = sel_owner;
                    r_d.was_dirty = rd_dirty;
                    r_d.pend      = sel_targets;
                    r_d.lat       = LW'(MEM_LAT - 1);
                    r_d.st        = (sel_targets != '0) ? ST_SEND : ST_MEMRD;
                end
            end
            ST_SEND: begin
                r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (ack_valid && ((r_q.pend & ack_oh) != '0)) begin
                    r_d.pend = pend_left;
                    if (pend_left == '0) begin
                        if (r_q.was_dirty) begin
                            mem_we   = 1'b1;
                            r_d.data = ack_data;
                            r_d.st   = ST_REPLY;
                        end else begin
                            r_d.lat = LW'(MEM_LAT - 1);
                            r_d.st  = ST_MEMRD;
                        end
                    end
                end
            end
            ST_MEMRD: begin
                if (r_q.lat == '0) begin
                    r_d.data = rd_data;
                    r_d.st   = ST_REPLY;
                end else begin
                    r_d.lat = r_q.lat - 1'b1;
                end
            end
            ST_REPLY: begin
                dir_we    = 1'b1;
                dir_pres  = r_q.write ? pid_oh : (rd_pres | pid_oh);
                dir_dirty = r_q.write || r_q.owner;
                r_d.st    = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready   = (r_q.st == ST_IDLE);
    assign msg_valid   = (r_q.st == ST_SEND);
    assign msg_kind    = r_q.write ? MSG_INVAL : MSG_RECALL;
    assign msg_addr    = r_q.addr;
    assign msg_targets = r_q.pend;
    assign rsp_valid   = (r_q.st == ST_REPLY);
    assign rsp_pid     = r_q.pid;
    assign rsp_addr    = r_q.addr;
    assign rsp_excl    = r_q.write;
    assign rsp_data    = r_q.data;

endmodule

// File: rtl/dircoh_home_chk.sv
module dircoh_home_chk #(
    parameter int NPROC = 4,
    parameter int PIDW  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [PIDW-1:0]  req_pid,
    input logic             msg_valid,
    input logic             msg_kind,
    input logic [NPROC-1:0] msg_targets,
    input logic             ack_valid,
    input logic [PIDW-1:0]  ack_pid,
    input logic             rsp_valid,
    input logic [PIDW-1:0]  rsp_pid
);

    logic [PIDW-1:0]  pid_l;
    logic [NPROC-1:0] pend_l, ack_oh, req_oh;

    for (genvar g = 0; g < NPROC; g++) begin : g_oh
        assign ack_oh[g] = (ack_pid == PIDW'(g));
        assign req_oh[g] = (pid_l == PIDW'(g));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pid_l  <= '0;
            pend_l <= '0;
        end else begin
            if (req_valid && req_ready) pid_l <= req_pid;
            if (msg_valid) pend_l <= msg_targets;
            else if (ack_valid) pend_l <= pend_l & ~ack_oh;
        end
    end

    assert_one_inflight_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_msg_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |=> !msg_valid);

    assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_msg_nonempty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_targets != '0));

    assert_self_excluded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> ((msg_targets & req_oh) == '0));

    assert_recall_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_kind) |-> ($countones(msg_targets) == 1));

    assert_acks_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (pend_l == '0));

    assert_rsp_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_pid == pid_l));

endmodule

bind dircoh_home dircoh_home_chk #(.NPROC(NPROC), .PIDW(PIDW)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_pid(req_pid), .msg_valid(msg_valid), .msg_kind(msg_kind),
    .msg_targets(msg_targets), .ack_valid(ack_valid), .ack_pid(ack_pid),
    .rsp_valid(rsp_valid), .rsp_pid(rsp_pid)
);

// File: tb/dircoh_home_tb_top.sv
module dircoh_home_tb_top;

    localparam int NPROC = 4;
    localparam int NBLK  = 8;
    localparam int DW    = 16;

    typedef struct packed {
        logic       wr;
        logic [1:0] pid;
        logic [2:0] addr;
        logic [3:0] tgt;
    } vec_t;

    // write, processor, block, expected message targets
    localparam vec_t VECS [12] = '{
        '{1'b0, 2'd0, 3'd3, 4'b0000},  // clean read
        '{1'b0, 2'd1, 3'd3, 4'b0000},
        '{1'b0, 2'd2, 3'd3, 4'b0000},
        '{1'b1, 2'd1, 3'd3, 4'b0101},  // write, sharers 0 and 2 invalidated
        '{1'b1, 2'd1, 3'd3, 4'b0000},  // owner write
        '{1'b0, 2'd3, 3'd3, 4'b0010},  // recall from owner 1
        '{1'b1, 2'd0, 3'd3, 4'b1010},  // write, sharers 1 and 3
        '{1'b1, 2'd2, 3'd3, 4'b0001},  // write, dirty at 0
        '{1'b0, 2'd2, 3'd3, 4'b0000},  // owner read
        '{1'b0, 2'd0, 3'd5, 4'b0000},
        '{1'b1, 2'd3, 3'd5, 4'b0001},
        '{1'b1, 2'd0, 3'd3, 4'b0100}   // write, dirty at 2
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] req_pid = '0;
    logic [2:0] req_addr = '0;
    logic ack_valid = 1'b0;
    logic [1:0] ack_pid = '0;
    logic [DW-1:0] ack_data = '0;
    logic req_ready, msg_valid, msg_kind, rsp_valid, rsp_excl;
    logic [2:0] msg_addr, rsp_addr;
    logic [NPROC-1:0] msg_targets;
    logic [1:0] rsp_pid;
    logic [DW-1:0] rsp_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [DW-1:0] mem_m   [NBLK];
    logic          dirty_m [NBLK];
    logic [1:0]    own_m   [NBLK];

    always #5 clk = ~clk;

    dircoh_home dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_pid(req_pid), .req_addr(req_addr),
        .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_addr(msg_addr),
        .msg_targets(msg_targets),
        .ack_valid(ack_valid), .ack_pid(ack_pid), .ack_data(ack_data),
        .rsp_valid(rsp_valid), .rsp_pid(rsp_pid), .rsp_addr(rsp_addr),
        .rsp_excl(rsp_excl), .rsp_data(rsp_data)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic run_txn(input int idx, input vec_t v);
        logic [DW-1:0] ackd, expd;
        logic seen;
        int n;
        ackd = DW'(16'hA000 + idx);
        if (v.tgt != '0 && dirty_m[v.addr]) expd = ackd;
        else expd = mem_m[v.addr];

        @(negedge clk);
        chk(req_ready == 1'b1, "R9", "ready before request", 32'(req_ready), 1);
        req_valid = 1'b1; req_write = v.wr; req_pid = v.pid; req_addr = v.addr;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R9", "ready while busy", 32'(req_ready), 0);

        if (v.tgt != '0) begin
            n = 0;
            while (!msg_valid && n < 10) begin @(negedge clk); n++; end
            chk(msg_valid && msg_targets == v.tgt, v.wr ? "R4/R6" : "R3",
                "message targets", 32'(msg_targets), 32'(v.tgt));
            chk(msg_kind == v.wr, v.wr ? "R5" : "R3", "message kind",
                32'(msg_kind), 32'(v.wr));
            chk(msg_addr == v.addr, "R10", "message address", 32'(msg_addr), 32'(v.addr));
            // acknowledgement from a processor that was not targeted
            @(negedge clk);
            ack_valid = 1'b1; ack_pid = v.pid; ack_data = 16'hBAD0;
            @(negedge clk);
            ack_valid = 1'b0;
            for (int p = 0; p < NPROC; p++) begin
                if (v.tgt[p]) begin
                    chk(!rsp_valid, "R8", "reply before all acks", 32'(rsp_valid), 0);
                    ack_valid = 1'b1; ack_pid = 2'(p); ack_data = ackd;
                    @(negedge clk);
                    ack_valid = 1'b0;
                end
            end
        end

        n = 0; seen = 1'b0;
        while (!rsp_valid && n < 20) begin
            if (msg_valid) seen = 1'b1;
            @(negedge clk);
            n++;
        end
        if (v.tgt == '0)
            chk(!seen, "R7", "message on hit or clean read", 32'(seen), 0);
        chk(rsp_valid, "R2", "reply present", 32'(rsp_valid), 1);
        chk(rsp_pid == v.pid && rsp_addr == v.addr, "R2", "reply pid/addr",
            {28'd0, rsp_pid, 2'd0}, {28'd0, v.pid, 2'd0});
        chk(rsp_excl == v.wr, "R4", "reply exclusive flag", 32'(rsp_excl), 32'(v.wr));
        chk(rsp_data == expd, (v.tgt != '0 && dirty_m[v.addr]) ? "R5" : "R2",
            "reply data", 32'(rsp_data), 32'(expd));

        if (v.tgt != '0 && dirty_m[v.addr]) mem_m[v.addr] = ackd;
        if (v.wr) begin
            dirty_m[v.addr] = 1'b1;
            own_m[v.addr]   = v.pid;
        end else if (!(dirty_m[v.addr] && own_m[v.addr] == v.pid)) begin
            dirty_m[v.addr] = 1'b0;
        end
        @(negedge clk);
        chk(req_ready == 1'b1, "R9", "ready after reply", 32'(req_ready), 1);
    endtask

    initial begin
        int n;
        for (int b = 0; b < NBLK; b++) begin
            mem_m[b]   = DW'(16'h1000 + b);
            dirty_m[b] = 1'b0;
            own_m[b]   = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 1);
        chk(msg_valid == 1'b0, "R1", "no message after reset", 32'(msg_valid), 0);
        chk(rsp_valid == 1'b0, "R1", "no reply after reset", 32'(rsp_valid), 0);

        // R8: a stray acknowledgement while idle has no effect
        ack_valid = 1'b1; ack_pid = 2'd2; ack_data = 16'hDEAD;
        @(negedge clk);
        ack_valid = 1'b0;
        chk(!rsp_valid && !msg_valid && req_ready, "R8", "stray ack while idle",
            {29'd0, rsp_valid, msg_valid, req_ready}, 32'd1);

        for (int i = 0; i < 12; i++) run_txn(i, VECS[i]);

        // R9: request held high while busy is not taken again until the reply
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_pid = 2'd1; req_addr = 3'd0;
        @(negedge clk);
        n = 0;
        while (!rsp_valid && n < 20) begin
            chk(req_ready == 1'b0, "R9", "held request while busy", 32'(req_ready), 0);
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        chk(rsp_valid && rsp_data == 16'h1000, "R1", "block 0 initial data",
            32'(rsp_data), 32'h1000);
        @(negedge clk);
        chk(!rsp_valid, "R10", "reply is a single pulse", 32'(rsp_valid), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule